// File: doc/BRIEF.md
# Backlight Power-Enable Sequencer

This block drives a lamp inverter through its power-up and power-down steps. It controls three things at the inverter: the supply enable, one of two dimming-control enables (internal analog level or external pulse-width input), and the lamp-on command. A host raises `on_req` to light the lamp and lowers it to turn the lamp off. The sequencer applies the steps in a fixed order and holds each one for at least its minimum gap. The gaps are given in milliseconds and converted to clock cycles from a clock-frequency parameter. After the lamp goes off, the sequencer enforces a minimum off time before the lamp can be lit again. Reset also starts this off time.

The dimming mode is sampled only while everything is off. Once the supply is up, the mode stays frozen until the power-down has finished. Exactly one dimming enable is active while dimming control is applied. The inverter's status line is watched while the lamp is lit. A low level that lasts long enough triggers a power-down and sets a sticky fault flag. The fault blocks any restart until the host clears it with everything off. A ready flag tells the host that the lamp is lit and no fault is pending.

Top module: `bl_power_seq`

## Requirements
- R1: While `rst_n` is low, every output is low. The minimum off time (R5) counts from the release of reset.
- R2: Power-up order is fixed. `supply_en` rises first. A dimming enable rises no earlier than SUP_DIM_MS·CLK_KHZ cycles after `supply_en`. `lamp_on` rises last, and only while the supply and one dimming enable are both high.
- R3: `lamp_on` rises no earlier than DIM_LAMP_MS·CLK_KHZ cycles after the dimming enable rose. It also rises no earlier than SUP_LAMP_MS·CLK_KHZ cycles after `supply_en` rose.
- R4: Power-down order is fixed. `lamp_on` falls first. The dimming enable falls at least DOWN_MS·CLK_KHZ cycles later. `supply_en` falls at least DOWN_MS·CLK_KHZ cycles after the dimming enable.
- R5: After `lamp_on` falls, it stays low for at least OFF_MS·CLK_KHZ cycles.
- R6: `mode_ext` selects the dimming enable. A value of 1 drives `dim_ext_en` and a value of 0 drives `dim_int_en`. The two are never high together. One of them is high whenever `lamp_on` is high.
- R7: `mode_ext` is sampled only while `supply_en` is low. A change while the supply is up has no effect on the dimming enables until the next power-up.
- R8: While lit, `status_ok` low for DEB_CYC consecutive cycles starts the power-down of R4. In the same cycle that `lamp_on` falls, `fault` goes high. A low run of DEB_CYC−1 cycles or fewer has no effect.
- R9: `fault` stays high until `fault_clr` is seen while `supply_en` is low. A clear during power-down is ignored. While `fault` is high, `on_req` cannot start a power-up.
- R10: If `on_req` drops during power-up, the power-down of R4 runs from the step already reached. A step that was never taken is skipped, and `lamp_on` never rises.
- R11: `ready` is high only while `lamp_on` is high and `fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserted asynchronously, released synchronously |
| on_req | input | 1 | Host request: 1 = lamp on, 0 = lamp off |
| mode_ext | input | 1 | Dimming mode: 1 = external pulse-width input, 0 = internal analog level |
| status_ok | input | 1 | Inverter status: 1 = normal, 0 = abnormal |
| fault_clr | input | 1 | Clears the sticky fault while the supply is off |
| supply_en | output | 1 | Inverter supply enable |
| dim_int_en | output | 1 | Internal dimming control driven |
| dim_ext_en | output | 1 | External pulse-width dimming control driven |
| lamp_on | output | 1 | Lamp-on command to the inverter |
| fault | output | 1 | Sticky status fault |
| ready | output | 1 | Lamp lit with no fault pending |

## Verification
The bench sets CLK_KHZ to 1, so each millisecond parameter equals one clock cycle. It uses 3, 8, 10, 20 and 2 cycles for the supply-to-dimming, dimming-to-lamp, supply-to-lamp, off and step-down gaps, and a debounce of 4 cycles. With these values a full power cycle takes a few dozen cycles. The off gap is longer than the power-up path, so both the first lamp-on after reset and every fast relight wait on the off timer. The dimming-to-lamp gap decides the earliest lamp-on within power-up. Aborts during the supply step and during the dimming step, and debounce runs one cycle short of and exactly at the limit, all fit within a few hundred cycles.

// File: rtl/bl_seq_pkg.sv
package bl_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RISE,
    ST_DIM,
    ST_LIT,
    ST_DN_DIM,
    ST_DN_SUP
  } bl_state_e;

  typedef enum logic [1:0] {
    STEP_SUP_DIM,
    STEP_DIM_LAMP,
    STEP_DOWN
  } bl_step_e;

  // Converts a gap in milliseconds to clock cycles, never below one cycle.
  function automatic int unsigned ms_cycles(input int unsigned ms, input int unsigned khz);
    int unsigned c;
    c = ms * khz;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/bl_gap_timer.sv
module bl_gap_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W'(RST_VAL);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/bl_status_filter.sv
module bl_status_filter #(
  parameter int unsigned DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic status_ok,
  output logic trip
);

  localparam int unsigned DW   = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
  localparam logic [DW-1:0] LAST = DW'(DEB_CYC - 1);

  logic [DW-1:0] low_q;
  logic [DW-1:0] low_d;
  logic          low_en;
  logic          bad;

  always_comb begin
    bad    = arm & ~status_ok;
    trip   = bad & (low_q == LAST);
    low_en = ~bad | (low_q != LAST);
    low_d  = bad ? (low_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (low_en) begin
      low_q <= low_d;
    end
  end

endmodule

// File: rtl/bl_seq_fsm.sv
module bl_seq_fsm
  import bl_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      on_req,
  input  logic      mode_ext,
  input  logic      fault_clr,
  input  logic      trip,
  input  logic      step_done,
  input  logic      gap_done,
  input  logic      off_done,
  output bl_state_e state_o,
  output logic      step_load,
  output bl_step_e  step_sel,
  output logic      gap_load,
  output logic      off_load,
  output logic      fault_o,
  output logic      mode_o
);

  bl_state_e state_q, state_d;
  logic      fault_q, fault_d;
  logic      mode_q, mode_d;
  logic      state_en, fault_en, mode_en;

  always_comb begin
    state_d   = state_q;
    fault_d   = fault_q;
    step_load = 1'b0;
    step_sel  = STEP_DOWN;
    gap_load  = 1'b0;
    off_load  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (fault_q) begin
          if (fault_clr) fault_d = 1'b0;
        end else if (on_req) begin
          state_d   = ST_RISE;
          step_load = 1'b1;
          step_sel  = STEP_SUP_DIM;
          gap_load  = 1'b1;
        end
      end
      ST_RISE: begin
        if (!on_req) begin
          state_d   = ST_DN_SUP;
          step_load = 1'b1;
        end else if (step_done) begin
          state_d   = ST_DIM;
          step_load = 1'b1;
          step_sel  = STEP_DIM_LAMP;
        end
      end
      ST_DIM: begin
        if (!on_req) begin
          state_d   = ST_DN_DIM;
          step_load = 1'b1;
        end else if (step_done && gap_done && off_done) begin
          state_d = ST_LIT;
        end
      end
      ST_LIT: begin
        if (trip || !on_req) begin
          state_d   = ST_DN_DIM;
          step_load = 1'b1;
          off_load  = 1'b1;
          if (trip) fault_d = 1'b1;
        end
      end
      ST_DN_DIM: begin
        if (step_done) begin
          state_d   = ST_DN_SUP;
          step_load = 1'b1;
        end
      end
      ST_DN_SUP: begin
        if (step_done) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
    mode_d   = (state_q == ST_OFF) ? mode_ext : mode_q;
    state_en = (state_d != state_q);
    fault_en = (fault_d != fault_q);
    mode_en  = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      fault_q <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      if (fault_en) fault_q <= fault_d;
      if (mode_en)  mode_q  <= mode_d;
    end
  end

  assign state_o = state_q;
  assign fault_o = fault_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/bl_power_seq.sv
module bl_power_seq
  import bl_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 200000,
  parameter int unsigned SUP_DIM_MS  = 30,
  parameter int unsigned DIM_LAMP_MS = 100,
  parameter int unsigned SUP_LAMP_MS = 300,
  parameter int unsigned OFF_MS      = 300,
  parameter int unsigned DOWN_MS     = 10,
  parameter int unsigned DEB_CYC     = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic mode_ext,
  input  logic status_ok,
  input  logic fault_clr,
  output logic supply_en,
  output logic dim_int_en,
  output logic dim_ext_en,
  output logic lamp_on,
  output logic fault,
  output logic ready
);

  localparam int unsigned SUP_DIM_CYC  = ms_cycles(SUP_DIM_MS, CLK_KHZ);
  localparam int unsigned DIM_LAMP_CYC = ms_cycles(DIM_LAMP_MS, CLK_KHZ);
  localparam int unsigned SUP_LAMP_CYC = ms_cycles(SUP_LAMP_MS, CLK_KHZ);
  localparam int unsigned OFF_CYC      = ms_cycles(OFF_MS, CLK_KHZ);
  localparam int unsigned DOWN_CYC     = ms_cycles(DOWN_MS, CLK_KHZ);
  localparam int unsigned MAX_A = (SUP_DIM_CYC > DIM_LAMP_CYC) ? SUP_DIM_CYC : DIM_LAMP_CYC;
  localparam int unsigned MAX_B = (SUP_LAMP_CYC > OFF_CYC) ? SUP_LAMP_CYC : OFF_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAXC  = (MAX_C > DOWN_CYC) ? MAX_C : DOWN_CYC;
  localparam int unsigned CW    = $clog2(MAXC + 1);
  localparam int unsigned NT    = 3;   // 0: step, 1: supply-to-lamp, 2: off time
  localparam int unsigned T_STEP = 0;
  localparam int unsigned T_GAP  = 1;
  localparam int unsigned T_OFF  = 2;

  bl_state_e      state;
  bl_step_e       step_sel;
  logic           step_load, gap_load, off_load;
  logic           trip, mode_q, dim_on;
  logic [NT-1:0]  tmr_load;
  logic [NT-1:0]  tmr_done;
  logic [CW-1:0]  tmr_val [NT];

  // Reload value of the shared step timer, chosen by the step being entered.
  always_comb begin
    unique case (step_sel)
      STEP_SUP_DIM:  tmr_val[T_STEP] = CW'(SUP_DIM_CYC - 1);
      STEP_DIM_LAMP: tmr_val[T_STEP] = CW'(DIM_LAMP_CYC - 1);
      default:       tmr_val[T_STEP] = CW'(DOWN_CYC - 1);
    endcase
    tmr_val[T_GAP]  = CW'(SUP_LAMP_CYC - 1);
    tmr_val[T_OFF]  = CW'(OFF_CYC - 1);
    tmr_load[T_STEP] = step_load;
    tmr_load[T_GAP]  = gap_load;
    tmr_load[T_OFF]  = off_load;
  end

  // The off timer comes out of reset already loaded, so the first
  // lamp-on after reset waits for the full off time.
  for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
    bl_gap_timer #(
      .W       (CW),
      .RST_VAL ((gi == T_OFF) ? (OFF_CYC - 1) : 0)
    ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load[gi]),
      .load_val (tmr_val[gi]),
      .done     (tmr_done[gi])
    );
  end

  bl_status_filter #(
    .DEB_CYC (DEB_CYC)
  ) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (lamp_on),
    .status_ok (status_ok),
    .trip      (trip)
  );

  bl_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_req    (on_req),
    .mode_ext  (mode_ext),
    .fault_clr (fault_clr),
    .trip      (trip),
    .step_done (tmr_done[T_STEP]),
    .gap_done  (tmr_done[T_GAP]),
    .off_done  (tmr_done[T_OFF]),
    .state_o   (state),
    .step_load (step_load),
    .step_sel  (step_sel),
    .gap_load  (gap_load),
    .off_load  (off_load),
    .fault_o   (fault),
    .mode_o    (mode_q)
  );

  always_comb begin
    supply_en  = (state != ST_OFF);
    dim_on     = (state == ST_DIM) || (state == ST_LIT) || (state == ST_DN_DIM);
    dim_int_en = dim_on & ~mode_q;
    dim_ext_en = dim_on & mode_q;
    lamp_on    = (state == ST_LIT);
    ready      = lamp_on & ~fault;
  end

endmodule

// File: rtl/bl_seq_chk.sv
module bl_seq_chk
  import bl_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 200000,
  parameter int unsigned SUP_DIM_MS  = 30,
  parameter int unsigned DIM_LAMP_MS = 100,
  parameter int unsigned SUP_LAMP_MS = 300,
  parameter int unsigned OFF_MS      = 300
) (
  input logic clk,
  input logic rst_n,
  input logic fault_clr,
  input logic supply_en,
  input logic dim_int_en,
  input logic dim_ext_en,
  input logic lamp_on,
  input logic fault
);

  localparam int unsigned SUP_DIM_CYC  = ms_cycles(SUP_DIM_MS, CLK_KHZ);
  localparam int unsigned DIM_LAMP_CYC = ms_cycles(DIM_LAMP_MS, CLK_KHZ);
  localparam int unsigned SUP_LAMP_CYC = ms_cycles(SUP_LAMP_MS, CLK_KHZ);
  localparam int unsigned OFF_CYC      = ms_cycles(OFF_MS, CLK_KHZ);

  logic        dim_any;
  logic [31:0] sup_age, dim_age, off_age;

  assign dim_any = dim_int_en | dim_ext_en;

  // Saturating ages of each level, counted in the checker itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_age <= '0;
      dim_age <= '0;
      off_age <= '0;
    end else begin
      sup_age <= !supply_en ? '0 : ((&sup_age) ? sup_age : sup_age + 1);
      dim_age <= !dim_any   ? '0 : ((&dim_age) ? dim_age : dim_age + 1);
      off_age <= lamp_on    ? '0 : ((&off_age) ? off_age : off_age + 1);
    end
  end

  assert_lamp_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_on) |-> supply_en && dim_any);
  assert_dim_needs_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dim_any |-> supply_en);
  assert_dim_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dim_any) |-> sup_age >= SUP_DIM_CYC);
  assert_lamp_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_on) |-> (dim_age >= DIM_LAMP_CYC) && (sup_age >= SUP_LAMP_CYC));
  assert_supply_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> !dim_any && !lamp_on);
  assert_dim_after_lamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dim_any) |-> !lamp_on);
  assert_off_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_on) |-> off_age >= OFF_CYC);
  assert_one_dim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dim_int_en, dim_ext_en}));
  assert_lit_has_dim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_on |-> $countones({dim_int_en, dim_ext_en}) == 1);
  assert_mode_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dim_any && $past(dim_any)) |-> $stable(dim_ext_en));
  assert_fault_drops_lamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $fell(lamp_on));
  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> $past(fault_clr) && !supply_en);
  assert_no_start_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) && fault |-> !$rose(supply_en));

endmodule

bind bl_power_seq bl_seq_chk #(
  .CLK_KHZ     (CLK_KHZ),
  .SUP_DIM_MS  (SUP_DIM_MS),
  .DIM_LAMP_MS (DIM_LAMP_MS),
  .SUP_LAMP_MS (SUP_LAMP_MS),
  .OFF_MS      (OFF_MS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_clr  (fault_clr),
  .supply_en  (supply_en),
  .dim_int_en (dim_int_en),
  .dim_ext_en (dim_ext_en),
  .lamp_on    (lamp_on),
  .fault      (fault)
);

// File: tb/bl_power_seq_test.sv
`timescale 1ns/1ps
module bl_power_seq_test;

  localparam int G_SD = 3, G_DL = 8, G_SL = 10, G_OFF = 20, G_DN = 2, DEB = 4;
  localparam int K_SUP_UP = 0, K_DI_UP = 1, K_DE_UP = 2, K_LAMP_UP = 3;
  localparam int K_LAMP_DN = 4, K_DIM_DN = 5, K_SUP_DN = 6;

  logic clk = 1'b0;
  logic rst_n, on_req, mode_ext, status_ok, fault_clr;
  logic supply_en, dim_int_en, dim_ext_en, lamp_on, fault, ready;

  always #2.5 clk = ~clk;

  bl_power_seq #(
    .CLK_KHZ(1), .SUP_DIM_MS(G_SD), .DIM_LAMP_MS(G_DL), .SUP_LAMP_MS(G_SL),
    .OFF_MS(G_OFF), .DOWN_MS(G_DN), .DEB_CYC(DEB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .mode_ext(mode_ext),
    .status_ok(status_ok), .fault_clr(fault_clr), .supply_en(supply_en),
    .dim_int_en(dim_int_en), .dim_ext_en(dim_ext_en), .lamp_on(lamp_on),
    .fault(fault), .ready(ready)
  );

  typedef struct {
    int    kind;
    string req;
    int    r0, m0, r1, m1, r2, m2;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   t_last [7];
  bit   mon_on = 1'b0;
  logic p_sup = 1'b0, p_di = 1'b0, p_de = 1'b0, p_lamp = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(input bit ok, input string req, input string what,
                              input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endfunction

  task automatic push(input int kind, input string req,
                      input int r0 = -1, input int m0 = 0,
                      input int r1 = -1, input int m1 = 0,
                      input int r2 = -1, input int m2 = 0);
    exp_t e;
    e.kind = kind; e.req = req;
    e.r0 = r0; e.m0 = m0; e.r1 = r1; e.m1 = m1; e.r2 = r2; e.m2 = m2;
    q.push_back(e);
  endtask

  function automatic void gap_chk(input int r, input int m, input string req);
    if (r >= 0) chk((cyc - t_last[r]) >= m, req, "minimum gap", cyc - t_last[r], m);
  endfunction

  function automatic void consume(input int k);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R2 R4 R9 R10", "unexpected output event", k, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == k, e.req, "event kind", k, e.kind);
      gap_chk(e.r0, e.m0, e.req);
      gap_chk(e.r1, e.m1, e.req);
      gap_chk(e.r2, e.m2, e.req);
    end
    t_last[k] = cyc;
  endfunction

  // Monitor: turns output edges into events and scores them against the queue.
  always @(negedge clk) begin
    if (mon_on) begin
      if (supply_en && !p_sup)    consume(K_SUP_UP);
      if (dim_int_en && !p_di)    consume(K_DI_UP);
      if (dim_ext_en && !p_de)    consume(K_DE_UP);
      if (lamp_on && !p_lamp)     consume(K_LAMP_UP);
      if (!lamp_on && p_lamp)     consume(K_LAMP_DN);
      if ((!dim_int_en && p_di) || (!dim_ext_en && p_de)) consume(K_DIM_DN);
      if (!supply_en && p_sup)    consume(K_SUP_DN);
    end
    p_sup = supply_en; p_di = dim_int_en; p_de = dim_ext_en; p_lamp = lamp_on;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_lamp;
    while (!lamp_on) @(negedge clk);
  endtask

  task automatic wait_supply_off;
    while (supply_en) @(negedge clk);
  endtask

  task automatic expect_down(input string req);
    push(K_LAMP_DN, req);
    push(K_DIM_DN, req, K_LAMP_DN, G_DN);
    push(K_SUP_DN, req, K_DIM_DN, G_DN);
  endtask

  task automatic expect_up(input int dim_kind, input string req);
    push(K_SUP_UP, req);
    push(dim_kind, req, K_SUP_UP, G_SD);
    push(K_LAMP_UP, req, dim_kind, G_DL, K_SUP_UP, G_SL, K_LAMP_DN, G_OFF);
  endtask

  function automatic void summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R2 R4): actual run still going at cycle %0d expected finish", cyc);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) t_last[i] = 0;
    rst_n = 1'b0; on_req = 1'b0; mode_ext = 1'b0; status_ok = 1'b1; fault_clr = 1'b0;
    tick(4);
    // R1: everything off in reset
    chk(supply_en == 1'b0, "R1", "supply_en in reset", supply_en, 0);
    chk({dim_int_en, dim_ext_en, lamp_on} == 3'b000, "R1", "dim/lamp in reset",
        {dim_int_en, dim_ext_en, lamp_on}, 0);
    chk({fault, ready} == 2'b00, "R1", "fault/ready in reset", {fault, ready}, 0);

    // First power-up, internal mode; off time counts from reset release (R1 R5)
    expect_up(K_DI_UP, "R1 R3 R5");
    rst_n = 1'b1; t_last[K_LAMP_DN] = cyc; mon_on = 1'b1; on_req = 1'b1;
    wait_lamp(); tick(1);
    chk(ready == 1'b1, "R11", "ready while lit", ready, 1);
    chk(dim_int_en == 1'b1, "R6", "internal enable selected", dim_int_en, 1);

    // R7: mode change while lit is ignored
    mode_ext = 1'b1; tick(5);
    chk({dim_int_en, dim_ext_en} == 2'b10, "R7", "dim enables after mode change",
        {dim_int_en, dim_ext_en}, 2);

    // R8: low run one cycle short of the debounce count
    status_ok = 1'b0; tick(DEB - 1); status_ok = 1'b1; tick(3);
    chk(lamp_on == 1'b1, "R8", "lamp after short low run", lamp_on, 1);
    chk(fault == 1'b0, "R8", "fault after short low run", fault, 0);

    // R4: orderly power-down
    expect_down("R4");
    on_req = 1'b0;
    wait_supply_off(); tick(1);
    chk(ready == 1'b0, "R11", "ready when off", ready, 0);

    // Fast relight in external mode: off time binds (R5, R6)
    expect_up(K_DE_UP, "R5 R6");
    on_req = 1'b1;
    wait_lamp(); tick(1);
    chk({dim_int_en, dim_ext_en} == 2'b01, "R6", "external enable selected",
        {dim_int_en, dim_ext_en}, 1);
    mode_ext = 1'b0; tick(3);
    chk(dim_ext_en == 1'b1, "R7", "external kept after mode change", dim_ext_en, 1);

    // R8: debounced fault
    expect_down("R8");
    status_ok = 1'b0;
    begin
      int n;
      n = 0;
      while (lamp_on) begin @(negedge clk); n++; end
      chk(n == DEB, "R8", "cycles from low status to lamp off", n, DEB);
    end
    status_ok = 1'b1;
    chk(fault == 1'b1, "R8", "fault set with lamp off", fault, 1);
    chk(ready == 1'b0, "R11", "ready with fault", ready, 0);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0; tick(1);
    chk(fault == 1'b1, "R9", "fault after clear during power-down", fault, 1);
    wait_supply_off(); tick(30);
    chk(supply_en == 1'b0, "R9", "no restart while faulted", supply_en, 0);
    chk(fault == 1'b1, "R9", "fault held while off", fault, 1);

    // R9: clear while off, then restart
    expect_up(K_DI_UP, "R9");
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    chk(fault == 1'b0, "R9", "fault after clear while off", fault, 0);
    wait_lamp(); tick(1);
    chk(ready == 1'b1, "R11", "ready after clear", ready, 1);
    expect_down("R4");
    on_req = 1'b0;
    wait_supply_off(); tick(2);

    // R10: abort during the supply step
    push(K_SUP_UP, "R10");
    push(K_SUP_DN, "R10", K_SUP_UP, G_DN);
    on_req = 1'b1;
    while (!supply_en) @(negedge clk);
    on_req = 1'b0;
    wait_supply_off(); tick(2);

    // R10: abort during the dimming step
    push(K_SUP_UP, "R10");
    push(K_DI_UP, "R10", K_SUP_UP, G_SD);
    push(K_DIM_DN, "R10", K_DI_UP, G_DN);
    push(K_SUP_DN, "R10", K_DIM_DN, G_DN);
    on_req = 1'b1;
    while (!dim_int_en) @(negedge clk);
    on_req = 1'b0;
    wait_supply_off(); tick(5);
    chk(lamp_on == 1'b0, "R10", "lamp after aborts", lamp_on, 0);

    chk(q.size() == 0, "R2", "expected events left over", q.size(), 0);
    summary();
    $finish;
  end

endmodule